// File: doc/BRIEF.md
# Predicate-result vector writeback sequencer

This block walks a vector of up to 32 elements, one element per clock, after a single start pulse. For each element it adds or subtracts two operands taken from an internal 32-entry integer array. It classifies the signed result into a 3-bit condition field and then decides what is written back. The operand and destination locations are base register numbers plus the element index, wrapping modulo 32. The condition field goes to a separate internal 32-entry condition array.

Two tests gate each element's stores. The first is the ordinary predicate mask bit. The second is a selectable test on one bit of the freshly computed condition field. An element that fails the condition test behaves as though its predicate bit were clear. A compare-only mode keeps the condition write and never stores the integer result. With zeroing enabled, an element that is masked out or fails the test writes zero to its integer destination instead of being skipped.

Per-element write strobes, addresses and data are brought out to the ports, so every writeback decision can be observed in the cycle it is made.

Top module: `predres_vec_seq`

## Requirements
- R1: Reset is synchronous and active high. It clears `busy`, `done` and both write strobes. It loads integer entry k with (k - 16) * 37 as a 32-bit two's-complement value, and clears every condition entry.
- R2: A `start` sampled while idle latches all controls. Element i, for i from 0 to VL-1, is then presented in the i-th cycle after that edge, with `busy` high. VL values above 32 are treated as 32. `done` is high for exactly one cycle, the cycle after the last element, and `busy` is then low.
- R3: A `start` with VL = 0 raises `done` in the next cycle. It raises no write strobe and never raises `busy`.
- R4: The element result is int[ra_base+i] + int[rb_base+i] when `op_sub` = 0, and int[ra_base+i] - int[rb_base+i] when `op_sub` = 1. All address sums wrap modulo 32. A write made by one element is seen by any later element that reads that entry.
- R5: The condition field is bit 0 = result less than zero (signed), bit 1 = result greater than zero, bit 2 = result equal to zero.
- R6: For an element whose predicate bit is set, the condition field is written to condition entry cr_base+i whenever `rc` or `rc1` is 1, whatever the outcome of the condition test.
- R7: With `zero_en` = 0, an element whose predicate bit (`pred_mask[i]`) is 0 raises neither write strobe.
- R8: `bo[1:0]` selects the tested bit: 0 = less-than, 1 = greater-than, 2 = equal, 3 = constant 0. The test passes when that bit equals `bo[2]`. If the test fails, the integer store of that element is cancelled.
- R9: When `rc1` = 1, no integer write is made for any element, zeroing included.
- R10: With `zero_en` = 1 and `rc1` = 0, an element that is masked out or fails the condition test writes zero to int[rt_base+i].
- R11: A `start` pulse while `busy` is high is ignored. The running vector continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector (sampled when idle) |
| vl | input | 6 | Vector length, 0 to 32 |
| pred_mask | input | 32 | Predicate bit per element |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| rc | input | 1 | Record condition fields |
| rc1 | input | 1 | Compare-only: record condition, discard result |
| bo | input | 3 | Condition test: [1:0] bit select, [2] required value |
| zero_en | input | 1 | Zero destinations of masked or failing elements |
| ra_base | input | 5 | First operand base register |
| rb_base | input | 5 | Second operand base register |
| rt_base | input | 5 | Integer destination base register |
| cr_base | input | 5 | Condition destination base entry |
| busy | output | 1 | An element is being processed this cycle |
| done | output | 1 | One-cycle completion pulse |
| elem_idx | output | 5 | Index of the element in flight |
| res_we | output | 1 | Integer write strobe for this element |
| res_addr | output | 5 | Integer destination entry |
| res_data | output | 32 | Value written to the integer entry |
| cr_we | output | 1 | Condition write strobe for this element |
| cr_addr | output | 5 | Condition destination entry |
| cr_data | output | 3 | Condition field written |

## Verification
The strobes, addresses and data of element i are combinational on the element counter. They are due in the i-th cycle after the start edge, and the array write lands on the edge that closes that cycle. `done` is due one cycle after the last element, or one cycle after the start edge when VL is 0. The bench advances its reference model at each rising edge, using the inputs held across that edge. It compares every output at the following falling edge, so each value is checked in exactly the cycle it is due.

// File: rtl/predres_pkg.sv
package predres_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);
    localparam int VLW  = AW + 1;

    typedef enum logic [0:0] {OP_ADD = 1'b0, OP_SUB = 1'b1} alu_op_e;

    typedef enum logic [1:0] {
        SEL_LT   = 2'd0,
        SEL_GT   = 2'd1,
        SEL_EQ   = 2'd2,
        SEL_ZERO = 2'd3
    } test_sel_e;

    typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_state_e;

    // bit 0 = lt, bit 1 = gt, bit 2 = eq
    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cond_t;

    typedef struct packed {
        alu_op_e         op;
        logic            keep_cr;
        logic            cmp_only;
        logic            want;
        test_sel_e       sel;
        logic            zeroing;
        logic [NREG-1:0] mask;
        logic [AW-1:0]   ra;
        logic [AW-1:0]   rb;
        logic [AW-1:0]   rt;
        logic [AW-1:0]   crb;
        logic [VLW-1:0]  vl;
    } vec_ctl_t;

    function automatic cond_t classify(input logic [XLEN-1:0] v);
        cond_t c;
        c.lt = v[XLEN-1];
        c.eq = (v == '0);
        c.gt = !v[XLEN-1] && (v != '0);
        return c;
    endfunction

    function automatic logic pick(input cond_t c, input test_sel_e s);
        case (s)
            SEL_LT:  return c.lt;
            SEL_GT:  return c.gt;
            SEL_EQ:  return c.eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] seed_value(input int k);
        return XLEN'((k - NREG / 2) * 37);
    endfunction

endpackage

// File: rtl/predres_rf.sv
module predres_rf
    import predres_pkg::*;
#(
    parameter int W      = 32,
    parameter int DEPTH  = 32,
    parameter int NRD    = 1,
    parameter bit SEEDED = 1'b0,
    localparam int RAW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NRD-1:0][RAW-1:0]  rd_a,
    output logic [NRD-1:0][W-1:0]    rd_d,
    input  logic                     we,
    input  logic [RAW-1:0]           wa,
    input  logic [W-1:0]             wd
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= SEEDED ? W'(seed_value(k)) : '0;
            end
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_d[p] = mem[rd_a[p]];
    end

endmodule

// File: rtl/predres_alu.sv
module predres_alu
    import predres_pkg::*;
(
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y,
    output cond_t            cond
);

    always_comb begin
        y    = (op == OP_SUB) ? (a - b) : (a + b);
        cond = classify(y);
    end

endmodule

// File: rtl/predres_wb.sv
module predres_wb
    import predres_pkg::*;
(
    input  logic             en,
    input  logic             act,
    input  cond_t            cond,
    input  test_sel_e        sel,
    input  logic             want,
    input  logic             keep_cr,
    input  logic             cmp_only,
    input  logic             zeroing,
    input  logic [XLEN-1:0]  y,
    output logic             res_we,
    output logic [XLEN-1:0]  res_d,
    output logic             cr_we
);

    logic test_ok;
    logic keep;

    always_comb begin
        test_ok = (pick(cond, sel) == want);
        keep    = act && test_ok;
        res_we  = en && !cmp_only && (keep || zeroing);
        res_d   = keep ? y : '0;
        cr_we   = en && act && (keep_cr || cmp_only);
    end

endmodule

// File: rtl/predres_vec_seq.sv
module predres_vec_seq
    import predres_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [VLW-1:0]      vl,
    input  logic [NREG-1:0]     pred_mask,
    input  logic                op_sub,
    input  logic                rc,
    input  logic                rc1,
    input  logic [2:0]          bo,
    input  logic                zero_en,
    input  logic [AW-1:0]       ra_base,
    input  logic [AW-1:0]       rb_base,
    input  logic [AW-1:0]       rt_base,
    input  logic [AW-1:0]       cr_base,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       elem_idx,
    output logic                res_we,
    output logic [AW-1:0]       res_addr,
    output logic [XLEN-1:0]     res_data,
    output logic                cr_we,
    output logic [AW-1:0]       cr_addr,
    output logic [2:0]          cr_data
);

    seq_state_e      state_q;
    vec_ctl_t        ctl_q;
    logic [AW-1:0]   idx_q;
    logic            done_q;
    logic [AW-1:0]   cr_last_q;

    logic                 is_last;
    logic                 act_w;
    logic                 cmp_w;
    logic                 zero_w;
    logic [1:0][AW-1:0]   op_addr;
    logic [1:0][XLEN-1:0] op_data;
    logic [XLEN-1:0]      alu_y;
    cond_t                alu_c;
    logic [0:0][2:0]      cr_peek;

    assign busy     = (state_q == S_RUN);
    assign done     = done_q;
    assign elem_idx = idx_q;
    assign is_last  = ((VLW'(idx_q) + VLW'(1)) == ctl_q.vl);
    assign act_w    = ctl_q.mask[idx_q];
    assign cmp_w    = ctl_q.cmp_only;
    assign zero_w   = ctl_q.zeroing;
    assign op_addr[0] = ctl_q.ra + idx_q;
    assign op_addr[1] = ctl_q.rb + idx_q;
    assign res_addr = ctl_q.rt + idx_q;
    assign cr_addr  = ctl_q.crb + idx_q;
    assign cr_data  = alu_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            ctl_q     <= '0;
            idx_q     <= '0;
            done_q    <= 1'b0;
            cr_last_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (cr_we) begin
                cr_last_q <= cr_addr;
            end
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ctl_q.op       <= alu_op_e'(op_sub);
                        ctl_q.keep_cr  <= rc;
                        ctl_q.cmp_only <= rc1;
                        ctl_q.want     <= bo[2];
                        ctl_q.sel      <= test_sel_e'(bo[1:0]);
                        ctl_q.zeroing  <= zero_en;
                        ctl_q.mask     <= pred_mask;
                        ctl_q.ra       <= ra_base;
                        ctl_q.rb       <= rb_base;
                        ctl_q.rt       <= rt_base;
                        ctl_q.crb      <= cr_base;
                        ctl_q.vl       <= (vl > VLW'(NREG)) ? VLW'(NREG) : vl;
                        idx_q          <= '0;
                        if (vl == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= S_RUN;
                        end
                    end
                end
                default: begin
                    if (is_last) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + AW'(1);
                    end
                end
            endcase
        end
    end

    predres_rf #(.W(XLEN), .DEPTH(NREG), .NRD(2), .SEEDED(1'b1)) u_int_rf (
        .clk  (clk),
        .rst  (rst),
        .rd_a (op_addr),
        .rd_d (op_data),
        .we   (res_we),
        .wa   (res_addr),
        .wd   (res_data)
    );

    predres_rf #(.W(3), .DEPTH(NREG), .NRD(1), .SEEDED(1'b0)) u_cr_rf (
        .clk  (clk),
        .rst  (rst),
        .rd_a (cr_last_q),
        .rd_d (cr_peek),
        .we   (cr_we),
        .wa   (cr_addr),
        .wd   (cr_data)
    );

    predres_alu u_alu (
        .op   (ctl_q.op),
        .a    (op_data[0]),
        .b    (op_data[1]),
        .y    (alu_y),
        .cond (alu_c)
    );

    predres_wb u_wb (
        .en       (busy),
        .act      (act_w),
        .cond     (alu_c),
        .sel      (ctl_q.sel),
        .want     (ctl_q.want),
        .keep_cr  (ctl_q.keep_cr),
        .cmp_only (cmp_w),
        .zeroing  (zero_w),
        .y        (alu_y),
        .res_we   (res_we),
        .res_d    (res_data),
        .cr_we    (cr_we)
    );

endmodule

// File: rtl/predres_chk.sv
module predres_chk
    import predres_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             res_we,
    input logic [XLEN-1:0]  res_data,
    input logic             cr_we,
    input logic [2:0]       cr_data,
    input logic             act,
    input logic             cmp_only,
    input logic             zeroing,
    input logic [2:0]       cr_peek
);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!res_we && !cr_we));

    assert_cond_single_R5: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones(cr_data) == 1));

    assert_cr_lands_R6: assert property (@(posedge clk) disable iff (rst)
        cr_we |=> (cr_peek == $past(cr_data)));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !act && !zeroing) |-> (!res_we && !cr_we));

    assert_cmp_no_store_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp_only) |-> !res_we);

    assert_zero_fill_R10: assert property (@(posedge clk) disable iff (rst)
        (res_we && !act) |-> (res_data == '0));

endmodule

bind predres_vec_seq predres_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .res_we   (res_we),
    .res_data (res_data),
    .cr_we    (cr_we),
    .cr_data  (cr_data),
    .act      (act_w),
    .cmp_only (cmp_w),
    .zeroing  (zero_w),
    .cr_peek  (cr_peek)
);

// File: tb/sim_predres_vec_seq.sv
module sim_predres_vec_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  vl = '0;
    logic [31:0] pred_mask = '0;
    logic        op_sub = 1'b0;
    logic        rc = 1'b0;
    logic        rc1 = 1'b0;
    logic [2:0]  bo = '0;
    logic        zero_en = 1'b0;
    logic [4:0]  ra_base = '0;
    logic [4:0]  rb_base = '0;
    logic [4:0]  rt_base = '0;
    logic [4:0]  cr_base = '0;
    logic        busy;
    logic        done;
    logic [4:0]  elem_idx;
    logic        res_we;
    logic [4:0]  res_addr;
    logic [31:0] res_data;
    logic        cr_we;
    logic [4:0]  cr_addr;
    logic [2:0]  cr_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    predres_vec_seq u0 (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .pred_mask(pred_mask),
        .op_sub(op_sub), .rc(rc), .rc1(rc1), .bo(bo), .zero_en(zero_en),
        .ra_base(ra_base), .rb_base(rb_base), .rt_base(rt_base), .cr_base(cr_base),
        .busy(busy), .done(done), .elem_idx(elem_idx), .res_we(res_we),
        .res_addr(res_addr), .res_data(res_data), .cr_we(cr_we),
        .cr_addr(cr_addr), .cr_data(cr_data)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    string cur_tag  = "R1";

    // reference model state
    logic [31:0] m_int [32];
    bit          m_run, m_done;
    int          m_idx, m_vl;
    bit          m_sub, m_rc, m_rc1, m_zero;
    logic [2:0]  m_bo;
    logic [31:0] m_mask;
    int          m_ra, m_rb, m_rt, m_crb;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 32; k++) m_int[k] = 32'((k - 16) * 37);
        m_run = 0; m_done = 0; m_idx = 0; m_vl = 0;
    endtask

    // compare the current cycle, then advance the model across the next edge
    task automatic step();
        logic [31:0] a, b, r, ed;
        logic [2:0]  c;
        bit          act, tbit, pass, ewe, ecw;
        int          it, ic;
        ewe = 0; ecw = 0; ed = '0; it = 0; ic = 0; c = '0;
        if (m_run) begin
            a  = m_int[(m_ra + m_idx) % 32];
            b  = m_int[(m_rb + m_idx) % 32];
            r  = m_sub ? (a - b) : (a + b);
            c  = {r == 0, $signed(r) > 0, $signed(r) < 0};
            act = m_mask[m_idx];
            case (m_bo[1:0])
                2'd0: tbit = c[0];
                2'd1: tbit = c[1];
                2'd2: tbit = c[2];
                default: tbit = 1'b0;
            endcase
            pass = (tbit == m_bo[2]);
            ecw = act && (m_rc || m_rc1);
            ewe = !m_rc1 && ((act && pass) || m_zero);
            ed  = (act && pass) ? r : 32'd0;
            it  = (m_rt + m_idx) % 32;
            ic  = (m_crb + m_idx) % 32;
            chk("elem_idx", 32'(elem_idx), 32'(m_idx));
        end
        chk("busy", 32'(busy), 32'(m_run));
        chk("done", 32'(done), 32'(m_done));
        chk("res_we", 32'(res_we), 32'(ewe));
        chk("cr_we", 32'(cr_we), 32'(ecw));
        if (ewe) begin
            chk("res_addr", 32'(res_addr), 32'(it));
            chk("res_data", res_data, ed);
        end
        if (ecw) begin
            chk("cr_addr", 32'(cr_addr), 32'(ic));
            chk("cr_data", 32'(cr_data), 32'(c));
        end
        @(posedge clk);
        if (m_run) begin
            if (ewe) m_int[it] = ed;
            m_done = (m_idx == m_vl - 1);
            if (m_done) m_run = 0;
            else m_idx++;
        end else begin
            m_done = 0;
            if (start) begin
                m_vl = (int'(vl) > 32) ? 32 : int'(vl);
                m_sub = op_sub; m_rc = rc; m_rc1 = rc1; m_bo = bo; m_zero = zero_en;
                m_mask = pred_mask; m_ra = ra_base; m_rb = rb_base;
                m_rt = rt_base; m_crb = cr_base; m_idx = 0;
                if (m_vl == 0) m_done = 1;
                else m_run = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic launch(input string tag, input int n, input logic [31:0] msk,
                          input bit sub, input bit f_rc, input bit f_rc1,
                          input logic [2:0] t_bo, input bit zr,
                          input int a, input int b, input int t, input int cb,
                          input int restart_at);
        int cyc;
        cur_tag = tag;
        vl = 6'(n); pred_mask = msk; op_sub = sub; rc = f_rc; rc1 = f_rc1;
        bo = t_bo; zero_en = zr; ra_base = 5'(a); rb_base = 5'(b);
        rt_base = 5'(t); cr_base = 5'(cb);
        start = 1'b1;
        step();
        start = 1'b0;
        cyc = 0;
        while (m_run || m_done) begin
            cyc++;
            if (cyc == restart_at) begin
                // R11: disturb the inputs and pulse start mid-run
                vl = 6'd3; op_sub = ~sub; rt_base = 5'd0; start = 1'b1;
            end
            step();
            start = 1'b0;
        end
        step();
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_tag = "R1";
        step();
        step();
        launch("R3",  0, 32'hFFFF_FFFF, 0, 1, 0, 3'b011, 0,  0,  0,  0,  0, 0);
        launch("R4",  8, 32'hFFFF_FFFF, 0, 1, 0, 3'b011, 0,  0, 20,  8,  0, 0);
        launch("R5", 10, 32'hFFFF_FFFF, 0, 1, 0, 3'b011, 0,  2, 24, 26,  5, 0);
        launch("R6", 10, 32'hFFFF_FFFF, 1, 1, 0, 3'b110, 0,  2, 24, 16,  9, 0);
        launch("R7", 12, 32'h0000_00A5, 0, 1, 0, 3'b011, 0,  3, 20, 18,  2, 0);
        launch("R8", 10, 32'hFFFF_FFFF, 0, 1, 0, 3'b100, 0,  2, 24, 16, 12, 0);
        launch("R10",16, 32'h0000_0F0F, 0, 1, 0, 3'b101, 1,  4, 12, 20,  0, 0);
        launch("R9",  6, 32'h0000_002D, 1, 0, 1, 3'b100, 1,  1,  9,  1,  7, 0);
        launch("R2", 40, 32'hDEAD_BEEF, 1, 0, 0, 3'b010, 0, 30, 17, 28, 31, 0);
        launch("R11", 9, 32'h0000_01FF, 0, 1, 0, 3'b011, 0,  5,  6,  7,  3, 4);
        launch("R4", 20, 32'hFFFF_FFFF, 0, 1, 0, 3'b011, 0, 28,  3, 30, 20, 0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule